// File: doc/BRIEF.md
# Ringing Supply Power Sequencer

This block brings up and tears down the two supplies behind a telephone bell driver. The first is a low-voltage rail, which also powers the supply comparators. The second is a high-voltage ringing supply. The block also decides when the ring PWM path may drive the bridge. A ring request starts an ordered climb. The low-voltage rail comes on first and is given a programmable number of timeout ticks to settle. Then the high-voltage supply is enabled, and the comparators stay masked until the undervoltage comparator reports power good. The mask is cleared one cycle before the ring gate opens.

Teardown runs the same order in reverse. The comparators are masked first, so the falling supplies cannot raise a fault. Then the high-voltage supply drops, and then the low-voltage rail. Lifting the handset closes the ring gate as soon as the synchronized hook level reaches it, even in the middle of a burst, and starts the teardown, so an answered call never leaves the high-voltage supply on. If power good does not arrive within a programmable number of ticks, both supplies are cut and a timeout flag is held until the request is withdrawn. An asynchronous power-on reset holds every enable and the gate low, with the mask set.

Top module: `ring_pwr_seq`

## Requirements
- R1: While rst_n is low, lv_en, hv_en, ring_gate and timeout_flag are 0 and cmp_mask is 1, taking effect without waiting for a clock edge.
- R2: With the handset on hook (synchronized hook low), a ring request in idle sets lv_en at the next edge with hv_en still 0. hv_en follows at the edge where the LV_SETTLE_TICKS-th tick is seen.
- R3: hv_en is never 1 while lv_en is 0.
- R4: After hv_en rises, cmp_mask stays 1 until pgood is sampled high; cmp_mask is 0 from the following edge.
- R5: ring_gate is 1 only while lv_en and hv_en are 1 and cmp_mask is 0, and it opens no earlier than one cycle after cmp_mask cleared.
- R6: On shutdown cmp_mask is 1 for at least one cycle before hv_en falls, and lv_en falls one cycle after hv_en.
- R7: hook_off_raw (1 = handset lifted) passes through two flip-flops. ring_gate is 0 after the second edge that follows the change, and hv_en is 0 two edges after that.
- R8: Dropping ring_req while ringing runs the same shutdown order: mask, then hv_en off, then lv_en off, then idle.
- R9: If pgood stays low for TIMEOUT_TICKS ticks after hv_en rose, both enables go to 0 together and timeout_flag goes to 1. The flag stays set while ring_req is held and clears the edge after ring_req is seen low.
- R10: A ring request is ignored while the synchronized hook is high in idle, and lv_en stays 0.
- R11: pgood is ignored while only the low-voltage rail is up; hv_en still waits the full settle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ring_req | input | 1 | Request to power up and ring |
| hook_off_raw | input | 1 | Unsynchronized hook switch, 1 = handset lifted |
| pgood | input | 1 | Undervoltage comparator, 1 = high-voltage supply good |
| tick | input | 1 | Timebase pulse used for settle and timeout counts |
| lv_en | output | 1 | Low-voltage rail enable (also powers the comparators) |
| hv_en | output | 1 | High-voltage ringing supply enable |
| cmp_mask | output | 1 | 1 = comparator outputs ignored |
| ring_gate | output | 1 | 1 = ring PWM allowed through to the bridge |
| timeout_flag | output | 1 | 1 = power good never arrived, both supplies cut |

## Verification
Several properties are checked on every cycle:
- the high-voltage supply never runs without the low rail;
- the gate opens only with both supplies up and the mask clear;
- the mask clears only after power good was sampled;
- the mask is already set whenever the high-voltage supply falls;
- a synchronized hook lift during ringing has the high-voltage supply off two edges later;
- a timeout always leaves both supplies off.

Only the bench scenarios can show the exact settle and timeout tick counts, that pgood is ignored during low-rail settling, and the two-edge latency through the hook synchronizer. They also show that a request is ignored while off hook, that the timeout flag clears when the request is withdrawn, and that an asynchronous reset in mid-ring closes everything at once.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LV_UP,
    ST_HV_UP,
    ST_ARM,
    ST_RING,
    ST_SHUT_MASK,
    ST_HV_DROP,
    ST_FAULT
  } seq_state_t;

  typedef struct packed {
    logic lv;
    logic hv;
    logic mask;
    logic ring;
    logic to;
  } seq_out_t;

  // Output levels for each state; outputs are registered from this.
  function automatic seq_out_t decode_outputs(input seq_state_t s);
    seq_out_t o;
    o = '{lv: 1'b0, hv: 1'b0, mask: 1'b1, ring: 1'b0, to: 1'b0};
    case (s)
      ST_LV_UP:     o.lv = 1'b1;
      ST_HV_UP:     begin o.lv = 1'b1; o.hv = 1'b1; end
      ST_ARM:       begin o.lv = 1'b1; o.hv = 1'b1; o.mask = 1'b0; end
      ST_RING:      begin o.lv = 1'b1; o.hv = 1'b1; o.mask = 1'b0; o.ring = 1'b1; end
      ST_SHUT_MASK: begin o.lv = 1'b1; o.hv = 1'b1; end
      ST_HV_DROP:   o.lv = 1'b1;
      ST_FAULT:     o.to = 1'b1;
      default:      o = '{lv: 1'b0, hv: 1'b0, mask: 1'b1, ring: 1'b0, to: 1'b0};
    endcase
    return o;
  endfunction

  // True on the tick that completes a window of 'limit' ticks.
  function automatic logic window_done(input logic [31:0] count,
                                       input logic        tick,
                                       input logic [31:0] limit);
    return tick && (count == limit - 32'd1);
  endfunction

endpackage

// File: rtl/rps_hook_sync.sv
module rps_hook_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= d_async;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rps_tick_timer.sv
module rps_tick_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (clr)                      count <= '0;
    else if (tick && count != CNT_MAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/rps_seq_fsm.sv
module rps_seq_fsm
  import rps_pkg::*;
#(
  parameter int LV_SETTLE_TICKS = 3,
  parameter int TIMEOUT_TICKS   = 16,
  parameter int CNT_W           = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_req,
  input  logic             hook_s,
  input  logic             pgood,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  output logic             timer_clr,
  output seq_state_t       state_q,
  output seq_out_t         out_q,
  output logic             ev_pgood_seen,
  output logic             ev_timeout,
  output logic             ev_hook_cut
);
  seq_state_t state_d;
  logic       abort;
  logic       settle_done;
  logic       wait_expired;

  assign abort        = hook_s || !ring_req;
  assign settle_done  = window_done(32'(count), tick, 32'(LV_SETTLE_TICKS));
  assign wait_expired = window_done(32'(count), tick, 32'(TIMEOUT_TICKS));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (ring_req && !hook_s) state_d = ST_LV_UP;
      ST_LV_UP:     if (abort)             state_d = ST_HV_DROP;
                    else if (settle_done)  state_d = ST_HV_UP;
      ST_HV_UP:     if (abort)             state_d = ST_SHUT_MASK;
                    else if (pgood)        state_d = ST_ARM;
                    else if (wait_expired) state_d = ST_FAULT;
      ST_ARM:       state_d = abort ? ST_SHUT_MASK : ST_RING;
      ST_RING:      if (abort)             state_d = ST_SHUT_MASK;
      ST_SHUT_MASK: state_d = ST_HV_DROP;
      ST_HV_DROP:   state_d = ST_IDLE;
      ST_FAULT:     if (!ring_req)         state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  assign timer_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      out_q   <= decode_outputs(ST_IDLE);
    end else begin
      state_q <= state_d;
      out_q   <= decode_outputs(state_d);
    end
  end

  assign ev_pgood_seen = (state_q == ST_HV_UP) && pgood && !abort;
  assign ev_timeout    = (state_q == ST_HV_UP) && (state_d == ST_FAULT);
  assign ev_hook_cut   = (state_q == ST_RING) && hook_s;
endmodule

// File: rtl/ring_pwr_seq.sv
module ring_pwr_seq
  import rps_pkg::*;
#(
  parameter int LV_SETTLE_TICKS = 3,
  parameter int TIMEOUT_TICKS   = 16,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_req,
  input  logic hook_off_raw,
  input  logic pgood,
  input  logic tick,
  output logic lv_en,
  output logic hv_en,
  output logic cmp_mask,
  output logic ring_gate,
  output logic timeout_flag
);
  localparam int MAX_WIN = (LV_SETTLE_TICKS > TIMEOUT_TICKS) ? LV_SETTLE_TICKS : TIMEOUT_TICKS;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);

  logic             hook_s;
  logic             timer_clr;
  logic [CNT_W-1:0] count;
  seq_state_t       state_q;
  seq_out_t         out_q;
  logic             ev_pgood_seen;
  logic             ev_timeout;
  logic             ev_hook_cut;

  rps_hook_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(hook_off_raw), .q_sync(hook_s)
  );

  rps_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr), .tick(tick), .count(count)
  );

  rps_seq_fsm #(
    .LV_SETTLE_TICKS(LV_SETTLE_TICKS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .ring_req(ring_req), .hook_s(hook_s),
    .pgood(pgood), .tick(tick), .count(count), .timer_clr(timer_clr),
    .state_q(state_q), .out_q(out_q), .ev_pgood_seen(ev_pgood_seen),
    .ev_timeout(ev_timeout), .ev_hook_cut(ev_hook_cut)
  );

  assign lv_en        = out_q.lv;
  assign hv_en        = out_q.hv;
  assign cmp_mask     = out_q.mask;
  assign timeout_flag = out_q.to;
  // Gate closes as soon as the synchronized hook level arrives (R7).
  assign ring_gate    = out_q.ring & ~hook_s;
endmodule

// File: rtl/rps_checker.sv
module rps_checker (
  input logic clk,
  input logic rst_n,
  input logic pgood,
  input logic lv_en,
  input logic hv_en,
  input logic cmp_mask,
  input logic ring_gate,
  input logic timeout_flag,
  input logic ev_pgood_seen,
  input logic ev_timeout,
  input logic ev_hook_cut
);
  assert_lv_before_hv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_en) |-> $past(lv_en));

  assert_hv_needs_lv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en |-> lv_en);

  assert_unmask_after_pgood_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_mask) |-> ($past(pgood) && hv_en));

  assert_pgood_unmasks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pgood_seen |=> !cmp_mask);

  assert_gate_needs_power_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ring_gate |-> (lv_en && hv_en && !cmp_mask));

  assert_gate_after_unmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_gate) |-> !$past(cmp_mask));

  assert_mask_before_hv_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_en) |-> $past(cmp_mask));

  assert_lv_after_hv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lv_en) && !timeout_flag) |-> !$past(hv_en));

  assert_hook_cuts_hv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hook_cut |-> ##2 !hv_en);

  assert_timeout_cuts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (timeout_flag && !hv_en && !lv_en));

  assert_flag_supplies_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> (!lv_en && !hv_en && !ring_gate));
endmodule

bind ring_pwr_seq rps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pgood(pgood), .lv_en(lv_en), .hv_en(hv_en),
  .cmp_mask(cmp_mask), .ring_gate(ring_gate), .timeout_flag(timeout_flag),
  .ev_pgood_seen(ev_pgood_seen), .ev_timeout(ev_timeout), .ev_hook_cut(ev_hook_cut)
);

// File: tb/ring_pwr_seq_test.sv
module ring_pwr_seq_test;
  localparam int SETTLE = 2;
  localparam int TMO    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_req = 1'b0, hook_off_raw = 1'b0, pgood = 1'b0, tick = 1'b0;
  logic lv_en, hv_en, cmp_mask, ring_gate, timeout_flag;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ring_pwr_seq #(.LV_SETTLE_TICKS(SETTLE), .TIMEOUT_TICKS(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .ring_req(ring_req), .hook_off_raw(hook_off_raw),
    .pgood(pgood), .tick(tick), .lv_en(lv_en), .hv_en(hv_en),
    .cmp_mask(cmp_mask), .ring_gate(ring_gate), .timeout_flag(timeout_flag)
  );

  // {req, hook, pgood, tick} -> expected {lv, hv, mask, gate, to}, requirement number
  typedef struct packed {
    logic [3:0] stim;
    logic [4:0] exp;
    logic [3:0] rid;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TABLE [NV] = '{
    '{4'b1000, 5'b10100, 4'd2},  // R2: lv first
    '{4'b1011, 5'b10100, 4'd11}, // R11: pgood ignored, tick 1
    '{4'b1000, 5'b10100, 4'd2},
    '{4'b1001, 5'b11100, 4'd2},  // R2: second tick brings hv
    '{4'b1001, 5'b11100, 4'd4},  // R4: mask held
    '{4'b1010, 5'b11000, 4'd4},  // R4: pgood clears mask
    '{4'b1010, 5'b11010, 4'd5},  // R5: gate opens a cycle later
    '{4'b1000, 5'b11010, 4'd5},
    '{4'b0000, 5'b11100, 4'd8},  // R8: mask first
    '{4'b0000, 5'b10100, 4'd6},  // R6: hv drops
    '{4'b0000, 5'b00100, 4'd6},  // R6: lv drops
    '{4'b1000, 5'b10100, 4'd2},
    '{4'b1001, 5'b10100, 4'd2},
    '{4'b1001, 5'b11100, 4'd2},
    '{4'b1001, 5'b11100, 4'd9},  // R9: waiting
    '{4'b1001, 5'b11100, 4'd9},
    '{4'b1001, 5'b11100, 4'd9},
    '{4'b1001, 5'b11100, 4'd9},
    '{4'b1001, 5'b00101, 4'd9},  // R9: fifth tick times out
    '{4'b1000, 5'b00101, 4'd9},  // R9: held
    '{4'b0000, 5'b00100, 4'd9}   // R9: cleared on request drop
  };

  function automatic logic [4:0] outs();
    return {lv_en, hv_en, cmp_mask, ring_gate, timeout_flag};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s: {lv,hv,mask,gate,to} actual %b expected %b", req, outs(), exp);
    end
  endtask

  task automatic step(input logic r, input logic h, input logic p, input logic t);
    ring_req = r; hook_off_raw = h; pgood = p; tick = t;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_ring();
    step(1, 0, 0, 0);
    step(1, 0, 0, 1);
    step(1, 0, 0, 1);
    step(1, 0, 1, 0);
    step(1, 0, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 5'b00100);                       // R1 reset state
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0);

    foreach (TABLE[i]) begin
      step(TABLE[i].stim[3], TABLE[i].stim[2], TABLE[i].stim[1], TABLE[i].stim[0]);
      check($sformatf("R%0d vector %0d", TABLE[i].rid, i), TABLE[i].exp);
    end

    // R7: lift handset mid-burst
    go_ring();
    check("R5 ringing", 5'b11010);
    step(1, 1, 1, 0);
    check("R7 one edge, sync not through", 5'b11010);
    step(1, 1, 1, 0);
    check("R7 gate cut after two edges", 5'b11000);
    step(1, 1, 1, 0);
    check("R7 mask set", 5'b11100);
    step(1, 1, 1, 0);
    check("R7 hv off after answer", 5'b10100);
    step(1, 1, 1, 0);
    check("R7 lv off", 5'b00100);
    repeat (3) step(1, 1, 0, 1);
    check("R10 request ignored off hook", 5'b00100);
    repeat (3) step(0, 0, 0, 0);

    // R7/R6: hook lift while waiting for pgood
    step(1, 0, 0, 0);
    step(1, 0, 0, 1);
    step(1, 0, 0, 1);
    check("R2 hv up", 5'b11100);
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    check("R6 mask held before hv drop", 5'b11100);
    step(1, 1, 0, 0);
    check("R6 hv dropped lv held", 5'b10100);
    step(1, 1, 0, 0);
    check("R6 idle", 5'b00100);
    repeat (3) step(0, 0, 0, 0);

    // R1: asynchronous reset mid-ring
    go_ring();
    check("R5 ringing again", 5'b11010);
    rst_n = 1'b0;
    #1;
    check("R1 async reset mid-ring", 5'b00100);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    check("R1 after release", 5'b00100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule